// File: doc/BRIEF.md
# Software Condition Select Register

This block lets a conditional instruction test one status source that software picks at run time. A small select register holds a condition code. A code in the low range points at one of the software interrupt bits. Two further codes point at dedicated status flags: ALU saturation and shifter overflow. The remaining codes are reserved and select no source.

Software loads the code through a single write port. The new code takes effect one cycle later than a plain register would allow. A test issued in the cycle that follows a write therefore still uses the earlier code. When the test strobe is raised, the block samples the selected source and registers the result, either as it is (the true test) or inverted (the not-true test). The result is returned with a valid pulse.

The flags and the interrupt latch and mask vectors are produced elsewhere in the chip. This block only reads them.

Top module: `swc_cond_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `cond_valid`, clears `cond_out` and sets the select code to 0x0. After reset, a test therefore reads software interrupt bit 0.
- R2: Select code 0x8 routes `alu_sat` to the condition.
- R3: Select code 0x9 routes `shf_ovf` to the condition.
- R4: A select code n from 0x0 to 0x7 makes the condition true exactly when bit n is set in both `irq_latch` and `irq_mask`.
- R5: Select codes 0xA to 0xF make the condition false. A true test on them returns 0 and an inverted test returns 1.
- R6: With `test_inv` high on a test, `cond_out` holds the inverse of the selected condition. With `test_inv` low, it holds the condition unchanged.
- R7: When `test_en` is high at edge k, `cond_valid` is high after edge k. `cond_out` then reflects the sources as sampled at edge k.
- R8: A write sampled at edge k (`sel_wr_en` high) becomes the select code at edge k+1. A test sampled at edge k or at edge k+1 uses the earlier code. A test sampled at edge k+2 uses the written code.
- R9: When `test_en` is low at an edge, `cond_valid` is low after that edge and `cond_out` keeps its previous value, whatever the sources do.
- R10: Writes on consecutive edges take effect one after another, each one edge later than its own write. The last write is the code that remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_wr_en | input | 1 | Write strobe for the select code |
| sel_wr_data | input | 4 | Select code to write |
| alu_sat | input | 1 | ALU saturation status flag |
| shf_ovf | input | 1 | Shifter overflow status flag |
| irq_latch | input | 8 | Software interrupt latch bits |
| irq_mask | input | 8 | Software interrupt mask bits |
| test_en | input | 1 | Test strobe |
| test_inv | input | 1 | 1 = inverted test, 0 = true test |
| cond_valid | output | 1 | Pulses one cycle after a test strobe |
| cond_out | output | 1 | Registered test result, held between tests |

## Verification
The case most likely to hide errors is a write to the select code that overlaps a test. It can fall in the same cycle as the test or in the cycle just before it. The bench raises the write strobe and the test strobe together, then keeps the test strobe high for two more cycles. The two flags are given opposite values, so each of the two codes gives a different answer. The first two results must follow the earlier code and the third must follow the new one. A second pattern writes on two edges in a row while tests run, to confirm that each code takes effect in turn.

// File: rtl/swc_pkg.sv
// Package: shared parameters and code constants for the software condition unit.
// Assumes the dedicated flag codes sit directly above the software interrupt codes.
package swc_pkg;
    parameter int SWC_CODE_W  = 4;
    parameter int SWC_NUM_SWI = 8;
endpackage

// File: rtl/swc_sel_reg.sv
// Module: swc_sel_reg
// Holds the condition select code. A write first lands in a staging register and
// only reaches the active code on the following edge, which gives the one-cycle
// write latency seen by tests.
// Assumes a synchronous active-low reset. The reset code is zero.
module swc_sel_reg #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] act_code
);
    logic [CODE_W-1:0] stage_q;
    logic              stage_vld_q;
    logic [CODE_W-1:0] act_q;

    // Capture a write into the staging register and mark it pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q     <= '0;
            stage_vld_q <= 1'b0;
        end else begin
            stage_vld_q <= wr_en;
            if (wr_en) begin
                stage_q <= wr_data;
            end
        end
    end

    // Move a pending staged code into the active code one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (stage_vld_q) begin
            act_q <= stage_q;
        end
    end

    assign act_code = act_q;
endmodule

// File: rtl/swc_src_mux.sv
// Module: swc_src_mux
// Combinational source selection. It builds one condition per possible code:
// software interrupt hits first, then the ALU and shifter flags, then constant
// false for the reserved codes. It then indexes that vector with the active code.
// Assumes 2**CODE_W >= NUM_SWI + 2.
module swc_src_mux #(
    parameter int CODE_W  = 4,
    parameter int NUM_SWI = 8
) (
    input  logic [CODE_W-1:0]  code,
    input  logic               alu_sat,
    input  logic               shf_ovf,
    input  logic [NUM_SWI-1:0] irq_latch,
    input  logic [NUM_SWI-1:0] irq_mask,
    output logic               cond_raw
);
    localparam int NUM_CODES = 1 << CODE_W;

    logic [NUM_CODES-1:0] cond_vec;

    // One decode slot per code; the parameters choose the source of each slot.
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_slot
        if (c < NUM_SWI) begin : g_swi
            assign cond_vec[c] = irq_latch[c] & irq_mask[c];
        end else if (c == NUM_SWI) begin : g_alu
            assign cond_vec[c] = alu_sat;
        end else if (c == NUM_SWI + 1) begin : g_shf
            assign cond_vec[c] = shf_ovf;
        end else begin : g_rsvd
            assign cond_vec[c] = 1'b0;
        end
    end

    // Pick the slot addressed by the active code.
    always_comb begin
        cond_raw = cond_vec[code];
    end
endmodule

// File: rtl/swc_test_unit.sv
// Module: swc_test_unit
// Registers the result of a test strobe, inverted when requested. It raises a
// one-cycle valid pulse and holds the last result between tests.
// Assumes a synchronous active-low reset.
module swc_test_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic test_inv,
    input  logic cond_raw,
    output logic cond_valid,
    output logic cond_out
);
    logic valid_q;
    logic res_q;

    // Produce the valid pulse and capture the polarity-adjusted result on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= 1'b0;
        end else begin
            valid_q <= test_en;
            if (test_en) begin
                res_q <= cond_raw ^ test_inv;
            end
        end
    end

    assign cond_valid = valid_q;
    assign cond_out   = res_q;
endmodule

// File: rtl/swc_cond_unit.sv
// Module: swc_cond_unit (top)
// Software condition unit: a select register with delayed write, a source
// multiplexer, and a registered true or inverted test.
// Assumes the status flags and interrupt vectors are synchronous to clk.
module swc_cond_unit #(
    parameter int CODE_W  = swc_pkg::SWC_CODE_W,
    parameter int NUM_SWI = swc_pkg::SWC_NUM_SWI
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr_en,
    input  logic [CODE_W-1:0]  sel_wr_data,
    input  logic               alu_sat,
    input  logic               shf_ovf,
    input  logic [NUM_SWI-1:0] irq_latch,
    input  logic [NUM_SWI-1:0] irq_mask,
    input  logic               test_en,
    input  logic               test_inv,
    output logic               cond_valid,
    output logic               cond_out
);
    logic [CODE_W-1:0] act_code;
    logic              cond_raw;

    swc_sel_reg #(.CODE_W(CODE_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sel_wr_en),
        .wr_data  (sel_wr_data),
        .act_code (act_code)
    );

    swc_src_mux #(.CODE_W(CODE_W), .NUM_SWI(NUM_SWI)) u_mux (
        .code      (act_code),
        .alu_sat   (alu_sat),
        .shf_ovf   (shf_ovf),
        .irq_latch (irq_latch),
        .irq_mask  (irq_mask),
        .cond_raw  (cond_raw)
    );

    swc_test_unit u_test (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (test_en),
        .test_inv   (test_inv),
        .cond_raw   (cond_raw),
        .cond_valid (cond_valid),
        .cond_out   (cond_out)
    );
endmodule

// File: rtl/swc_cond_chk.sv
// Module: swc_cond_chk
// Property checker bound to swc_cond_unit. It relates the active select code,
// the inputs and the registered result over time.
module swc_cond_chk #(
    parameter int CODE_W  = 4,
    parameter int NUM_SWI = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sel_wr_en,
    input logic [CODE_W-1:0]  sel_wr_data,
    input logic               alu_sat,
    input logic               shf_ovf,
    input logic [NUM_SWI-1:0] irq_latch,
    input logic [NUM_SWI-1:0] irq_mask,
    input logic               test_en,
    input logic               test_inv,
    input logic               cond_valid,
    input logic               cond_out,
    input logic [CODE_W-1:0]  act_code
);
    localparam int IDX_W = (NUM_SWI > 1) ? $clog2(NUM_SWI) : 1;
    localparam logic [CODE_W-1:0] CODE_ALU = CODE_W'(NUM_SWI);
    localparam logic [CODE_W-1:0] CODE_SHF = CODE_W'(NUM_SWI + 1);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (act_code == '0 && !cond_valid && !cond_out));

    assert_alu_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !test_inv && act_code == CODE_ALU) |=> (cond_out == $past(alu_sat)));

    assert_shf_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !test_inv && act_code == CODE_SHF) |=> (cond_out == $past(shf_ovf)));

    assert_swi_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !test_inv && act_code < CODE_ALU) |=>
        (cond_out == $past(irq_latch[act_code[IDX_W-1:0]] & irq_mask[act_code[IDX_W-1:0]])));

    assert_reserved_false_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && act_code > CODE_SHF) |=> (cond_out == $past(test_inv)));

    assert_strobe_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> cond_valid);

    assert_write_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_en |=> ##1 (act_code == $past(sel_wr_data, 2)));

    assert_no_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr_en |=> ##1 $stable(act_code));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (!cond_valid && $stable(cond_out)));
endmodule

bind swc_cond_unit swc_cond_chk #(.CODE_W(CODE_W), .NUM_SWI(NUM_SWI)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_wr_en   (sel_wr_en),
    .sel_wr_data (sel_wr_data),
    .alu_sat     (alu_sat),
    .shf_ovf     (shf_ovf),
    .irq_latch   (irq_latch),
    .irq_mask    (irq_mask),
    .test_en     (test_en),
    .test_inv    (test_inv),
    .cond_valid  (cond_valid),
    .cond_out    (cond_out),
    .act_code    (act_code)
);

// File: tb/tb_swc_cond_unit.sv
module tb_swc_cond_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr_en = 1'b0;
    logic [3:0] sel_wr_data = 4'h0;
    logic       alu_sat = 1'b0;
    logic       shf_ovf = 1'b0;
    logic [7:0] irq_latch = 8'h00;
    logic [7:0] irq_mask = 8'h00;
    logic       test_en = 1'b0;
    logic       test_inv = 1'b0;
    logic       cond_valid;
    logic       cond_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    swc_cond_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_wr_en   (sel_wr_en),
        .sel_wr_data (sel_wr_data),
        .alu_sat     (alu_sat),
        .shf_ovf     (shf_ovf),
        .irq_latch   (irq_latch),
        .irq_mask    (irq_mask),
        .test_en     (test_en),
        .test_inv    (test_inv),
        .cond_valid  (cond_valid),
        .cond_out    (cond_out)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [3:0] code;
        logic       alu;
        logic       shf;
        logic [7:0] lat;
        logic [7:0] msk;
        logic       inv;
        logic       exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'h8, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1},  // R2 alu set
        '{4'h8, 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0},  // R2 alu clear, others set
        '{4'h9, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1},  // R3 shifter set
        '{4'h9, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},  // R3 R6 inverted clear
        '{4'h3, 1'b0, 1'b0, 8'h08, 8'h08, 1'b0, 1'b1},  // R4 latched and enabled
        '{4'h3, 1'b0, 1'b0, 8'h08, 8'hF7, 1'b0, 1'b0},  // R4 mask bit clear
        '{4'h3, 1'b1, 1'b1, 8'hF7, 8'hFF, 1'b0, 1'b0},  // R4 latch bit clear
        '{4'h7, 1'b0, 1'b0, 8'h80, 8'h80, 1'b1, 1'b0},  // R4 R6 top bit inverted
        '{4'h0, 1'b0, 1'b0, 8'h01, 8'h01, 1'b0, 1'b1},  // R4 bottom bit
        '{4'hC, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0},  // R5 reserved true test
        '{4'hF, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1},  // R5 reserved inverted
        '{4'h5, 1'b0, 1'b0, 8'h20, 8'h20, 1'b1, 1'b0}   // R6 inverted hit
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic apply_vec(input vec_t v);
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_data = v.code; test_en = 1'b0;
        @(negedge clk);
        sel_wr_en = 1'b0;
        @(negedge clk);
        alu_sat = v.alu; shf_ovf = v.shf; irq_latch = v.lat; irq_mask = v.msk;
        test_en = 1'b1; test_inv = v.inv;
        tick();
        chk("R7 valid", cond_valid, 1'b1);
        chk("R2-R6 vector", cond_out, v.exp);
        @(negedge clk);
        test_en = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid", cond_valid, 1'b0);
        chk("R1 out", cond_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_latch = 8'h01; irq_mask = 8'h01; test_en = 1'b1; test_inv = 1'b0;
        tick();
        chk("R1 code zero", cond_out, 1'b1);
        @(negedge clk);
        test_en = 1'b0;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            apply_vec(VECS[i]);
        end

        // R8: write overlapping tests; code 8 -> 9, alu=1 shf=0
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_data = 4'h8;
        @(negedge clk);
        sel_wr_en = 1'b0;
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_data = 4'h9;
        alu_sat = 1'b1; shf_ovf = 1'b0; test_en = 1'b1; test_inv = 1'b0;
        tick();
        chk("R8 same cycle old code", cond_out, 1'b1);
        @(negedge clk);
        sel_wr_en = 1'b0;
        tick();
        chk("R8 next cycle old code", cond_out, 1'b1);
        tick();
        chk("R8 second cycle new code", cond_out, 1'b0);

        // R9: no strobe holds result while sources change
        @(negedge clk);
        test_en = 1'b0; shf_ovf = 1'b1; alu_sat = 1'b0;
        tick();
        chk("R9 valid low", cond_valid, 1'b0);
        chk("R9 hold", cond_out, 1'b0);
        tick();
        chk("R9 hold again", cond_out, 1'b0);

        // R7: sources sampled at strobe edge only
        @(negedge clk);
        test_en = 1'b1;
        tick();
        chk("R7 sample", cond_out, 1'b1);
        @(negedge clk);
        test_en = 1'b0; shf_ovf = 1'b0;
        tick();
        chk("R7 no resample", cond_out, 1'b1);

        // R10: back-to-back writes 8 then 9
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_data = 4'h8;
        @(negedge clk);
        sel_wr_data = 4'h9;
        @(negedge clk);
        sel_wr_en = 1'b0; alu_sat = 1'b1; shf_ovf = 1'b0; test_en = 1'b1;
        tick();
        chk("R10 first write active", cond_out, 1'b1);
        tick();
        chk("R10 last write active", cond_out, 1'b0);

        // R1: mid-run reset returns code to zero
        @(negedge clk);
        test_en = 1'b0; rst_n = 1'b0;
        tick();
        chk("R1 reset valid", cond_valid, 1'b0);
        chk("R1 reset out", cond_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_latch = 8'h01; irq_mask = 8'h01; test_en = 1'b1; test_inv = 1'b0;
        tick();
        chk("R1 code zero after reset", cond_out, 1'b1);
        @(negedge clk);
        test_en = 1'b0;
        tick();

        finish_run();
    end
endmodule